// File: doc/BRIEF.md
# GPIO Interrupt Trigger and Status Unit

This unit watches a vector of already-synchronized GPIO pin levels. For each pin it checks for an interrupt condition chosen by three trigger-control bits. A pin can fire on a rising edge, a falling edge, either edge, a high level or a low level. When the condition holds, the pin's status bit is set and stays set until it is cleared. The status bits are grouped into 32-bit words. A single combined interrupt line tells the host that at least one bit is pending.

The host works through a simple register bus. It reads a status word to find the pins that fired. It then writes ones to the bits it has handled, which clears them, and zeros leave bits untouched. Writing all ones clears a whole word. A new event that arrives in the same cycle as a clear always wins, so no event is lost. A level-triggered pin keeps setting its bit for as long as the level persists, including right after a clear.

Top module: `gpio_irq_unit`

## Requirements
- R1: With the trigger field {neg,pos,lvl} of a pin equal to 3'b010 (cfg bits 3n+2, 3n+1, 3n), a 0-to-1 change of the pin between two consecutive cycles sets the pin's status bit.
- R2: With the field equal to 3'b100, a 1-to-0 change of the pin sets its status bit.
- R3: With the field equal to 3'b110, a change in either direction sets the status bit, and a steady level does not set it.
- R4: With lvl=1, pos=1 sets the bit on every cycle the pin is high, and neg=1 sets it on every cycle the pin is low. The bit reappears the cycle after a clear if the level still holds.
- R5: With pos=0 and neg=0, the status bit is never set, whatever the lvl bit and the pin do.
- R6: Pin n lives in bit n mod 32 of the status word at byte address 0x800 + 4*(n/32). A read (busSel=1, busWr=0) returns that word on busRData one cycle later. A read of any other address, or of a misaligned one, returns 0.
- R7: A write to a status word clears every bit whose write-data bit is 1 and leaves bits written with 0 unchanged. All ones clears the whole word. Writes to other addresses have no effect.
- R8: When a trigger condition and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R9: irqOut is 1 exactly in the cycle after one in which any status bit was set.
- R10: Reset clears all status bits and irqOut. The previous-level register is loaded from the pins during reset, so no edge is detected on the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pinLevel | input | NUM_PINS | Synchronized pin levels |
| trigCfg | input | 3*NUM_PINS | Per-pin trigger field {neg,pos,lvl} at bits 3n+2..3n |
| busSel | input | 1 | Bus access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWData | input | 32 | Write data, ones clear status bits |
| busRData | output | 32 | Read data, valid the cycle after a read |
| irqOut | output | 1 | Combined interrupt, registered OR of all status bits |

## Verification
The bench aims at four cases:
- A pin edge that lands in the same cycle as its write-1 clear. A design with the clear winning would drop that event.
- A held level after a clear. An edge-only latch would stay clear here, when the bit must come straight back.
- A steady both-edge pin on the first cycle after reset. A previous-level register reset to zero would report a false rising edge.
- Zero writes, misaligned writes and out-of-range word addresses, together with the pin-to-word mapping above bit 31. A sloppy address decode would wipe or misplace bits in these cases.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 8;

  typedef struct packed {
    logic neg;
    logic pos;
    logic lvl;
  } trig_cfg_t;

  typedef struct packed {
    logic              clrEn;
    logic [IDX_W-1:0]  clrIdx;
    logic [WORD_W-1:0] clrMask;
    logic              rdEn;
    logic [IDX_W-1:0]  rdIdx;
  } strobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int              NUM_WORDS   = 2,
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] STATUS_BASE = 12'h800
) (
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWData,
  output strobe_t             strobes
);
  localparam logic [ADDR_W-1:0] WORDS_L = ADDR_W'(NUM_WORDS);

  logic [ADDR_W-1:0] offs;
  logic              inWindow;
  logic [IDX_W-1:0]  wordIdx;

  always_comb begin
    offs     = busAddr - STATUS_BASE;
    inWindow = (busAddr >= STATUS_BASE) && (offs[1:0] == 2'b00) &&
               ({2'b00, offs[ADDR_W-1:2]} < WORDS_L);
    wordIdx  = IDX_W'(offs[ADDR_W-1:2]);

    strobes.clrEn   = busSel && busWr && inWindow;
    strobes.clrIdx  = wordIdx;
    strobes.clrMask = busWData;
    strobes.rdEn    = busSel && !busWr && inWindow;
    strobes.rdIdx   = wordIdx;
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pinLevel,
  input  logic [3*NUM_PINS-1:0] trigCfg,
  input  strobe_t               strobes,
  output logic [WORD_W-1:0]     rdData,
  output logic                  irqOut,
  output logic [NUM_PINS-1:0]   statusVec
);
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_WORDS * WORD_W;

  logic [NUM_PINS-1:0] prevLevel;
  logic [NUM_PINS-1:0] hitVec;
  logic [NUM_PINS-1:0] clrVec;
  logic [PAD_W-1:0]    statusPad;
  logic [WORD_W-1:0]   rdWord;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    trig_cfg_t cfg;
    logic      riseEv;
    logic      fallEv;
    assign cfg    = trig_cfg_t'(trigCfg[3*i +: 3]);
    assign riseEv = pinLevel[i] & ~prevLevel[i];
    assign fallEv = ~pinLevel[i] & prevLevel[i];
    assign hitVec[i] = cfg.lvl ? ((cfg.pos & pinLevel[i]) | (cfg.neg & ~pinLevel[i]))
                               : ((cfg.pos & riseEv) | (cfg.neg & fallEv));
    assign clrVec[i] = strobes.clrEn &&
                       (strobes.clrIdx == IDX_W'(i / WORD_W)) &&
                       strobes.clrMask[i % WORD_W];
  end

  always_comb begin
    statusPad = '0;
    statusPad[NUM_PINS-1:0] = statusVec;
  end

  always_comb begin
    rdWord = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strobes.rdEn && strobes.rdIdx == IDX_W'(w))
        rdWord = statusPad[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    prevLevel <= pinLevel;
    if (!rst_n) begin
      statusVec <= '0;
      irqOut    <= 1'b0;
      rdData    <= '0;
    end else begin
      statusVec <= (statusVec & ~clrVec) | hitVec;
      irqOut    <= |statusVec;
      rdData    <= rdWord;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int                NUM_PINS    = 64,
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] STATUS_BASE = 12'h800
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pinLevel,
  input  logic [3*NUM_PINS-1:0] trigCfg,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWData,
  output logic [31:0]           busRData,
  output logic                  irqOut
);
  localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;

  strobe_t             strobes;
  logic [NUM_PINS-1:0] statusVec;

  gpio_irq_ctrl #(
    .NUM_WORDS  (NUM_WORDS),
    .ADDR_W     (ADDR_W),
    .STATUS_BASE(STATUS_BASE)
  ) u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWData(busWData),
    .strobes (strobes)
  );

  gpio_irq_datapath #(
    .NUM_PINS(NUM_PINS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinLevel (pinLevel),
    .trigCfg  (trigCfg),
    .strobes  (strobes),
    .rdData   (busRData),
    .irqOut   (irqOut),
    .statusVec(statusVec)
  );
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int                NUM_PINS    = 64,
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] STATUS_BASE = 12'h800
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   pinLevel,
  input logic [3*NUM_PINS-1:0] trigCfg,
  input logic                  busSel,
  input logic                  busWr,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [31:0]           busWData,
  input logic [31:0]           busRData,
  input logic                  irqOut,
  input logic [NUM_PINS-1:0]   statusVec
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;

  logic validAddr;
  always_comb begin
    validAddr = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (busAddr == STATUS_BASE + ADDR_W'(4*w)) validAddr = 1'b1;
  end

  // R9: combined line follows the OR of status one cycle later
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|statusVec) |=> irqOut);
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|statusVec) |=> !irqOut);

  // R6: reads outside the status words return zero
  p_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busSel && !busWr && !validAddr) |=> (busRData == 32'd0));

  // R10: reset empties status and the combined line
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (statusVec == '0 && !irqOut));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic lvl, pos, neg, clrHit;
    assign lvl = trigCfg[3*i];
    assign pos = trigCfg[3*i+1];
    assign neg = trigCfg[3*i+2];
    assign clrHit = busSel && busWr &&
                    (busAddr == STATUS_BASE + ADDR_W'(4*(i/32))) && busWData[i%32];

    // R1 and R8: a rising edge sets the bit even when cleared at once
    p_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl && pos && pinLevel[i] && !$past(pinLevel[i])) |=> statusVec[i]);
    // R2
    p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl && neg && !pinLevel[i] && $past(pinLevel[i])) |=> statusVec[i]);
    // R4
    p_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl && ((pos && pinLevel[i]) || (neg && !pinLevel[i]))) |=> statusVec[i]);
    // R5
    p_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pos && !neg && !statusVec[i]) |=> !statusVec[i]);
    // R7: without a write-1 the bit stays set
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (statusVec[i] && !clrHit) |=> statusVec[i]);
  end
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
  .NUM_PINS   (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .STATUS_BASE(STATUS_BASE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pinLevel (pinLevel),
  .trigCfg  (trigCfg),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWData (busWData),
  .busRData (busRData),
  .irqOut   (irqOut),
  .statusVec(statusVec)
);

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pinLevel = '0;
  logic [3*NP-1:0] trigCfg = '0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWData = '0;
  logic [31:0]   busRData;
  logic          irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NP-1:0] mStat = '0;
  logic [NP-1:0] mPrev = '0;

  always #2.5 clk = ~clk;

  gpio_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .pinLevel(pinLevel), .trigCfg(trigCfg),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .irqOut(irqOut)
  );

  function automatic logic [NP-1:0] calcHit(logic [NP-1:0] lv, logic [NP-1:0] pv,
                                            logic [3*NP-1:0] cf);
    logic [NP-1:0] h = '0;
    for (int n = 0; n < NP; n++) begin
      if (cf[3*n]) h[n] = (cf[3*n+1] && lv[n]) || (cf[3*n+2] && !lv[n]);
      else         h[n] = (cf[3*n+1] && lv[n] && !pv[n]) || (cf[3*n+2] && !lv[n] && pv[n]);
    end
    return h;
  endfunction

  function automatic int wordOf(logic [11:0] a);
    if (a == 12'h800) return 0;
    if (a == 12'h804) return 1;
    return -1;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, model the rising edge, compare at the next falling edge
  task automatic cyc(logic [NP-1:0] lv, logic [3*NP-1:0] cf, logic sel, logic wr,
                     logic [11:0] a, logic [31:0] wd, string tag);
    logic [31:0]   expRd;
    logic          expIrq;
    logic [NP-1:0] clr;
    int            w;
    pinLevel = lv; trigCfg = cf; busSel = sel; busWr = wr; busAddr = a; busWData = wd;
    @(posedge clk);
    w = wordOf(a);
    expRd  = (sel && !wr && w >= 0) ? mStat[w*32 +: 32] : 32'd0;
    expIrq = |mStat;
    clr = '0;
    if (sel && wr && w >= 0) clr[w*32 +: 32] = wd;
    mStat = (mStat & ~clr) | calcHit(lv, mPrev, cf);
    mPrev = lv;
    @(negedge clk);
    check(tag, busRData, expRd);
    check("R9 irqOut", {31'd0, irqOut}, {31'd0, expIrq});
  endtask

  task automatic idle(string tag);
    cyc(pinLevel, trigCfg, 1'b0, 1'b0, 12'h000, 32'd0, tag);
  endtask
  task automatic rd(logic [11:0] a, string tag);
    cyc(pinLevel, trigCfg, 1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    cyc(pinLevel, trigCfg, 1'b1, 1'b1, a, d, tag);
  endtask
  task automatic setPin(int n, logic v);
    logic [NP-1:0] l = pinLevel;
    l[n] = v;
    cyc(l, trigCfg, 1'b0, 1'b0, 12'h000, 32'd0, "edge");
  endtask
  function automatic logic [3*NP-1:0] oneCfg(int n, logic [2:0] f);
    logic [3*NP-1:0] c = '0;
    c[3*n +: 3] = f;
    return c;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int dummy;
    logic [NP-1:0] lv;
    logic [3*NP-1:0] cf;
    logic [11:0] addrSet [4];
    dummy = $urandom(32'h1357);
    addrSet[0] = 12'h800; addrSet[1] = 12'h804; addrSet[2] = 12'h808; addrSet[3] = 12'h000;

    // R10: reset with pins 0101... and both-edge triggers on every pin
    lv = {32{2'b01}};
    for (int n = 0; n < NP; n++) cf[3*n +: 3] = 3'b110;
    pinLevel = lv; trigCfg = cf;
    repeat (4) @(negedge clk);
    check("R10 reset irqOut", {31'd0, irqOut}, 32'd0);
    check("R10 reset rdata", busRData, 32'd0);
    rst_n = 1'b1;
    mPrev = lv; mStat = '0;
    idle("R10 first cycle");
    rd(12'h800, "R10 no edge word0");
    rd(12'h804, "R10 no edge word1");

    // R1 rising on pin 5
    trigCfg = oneCfg(5, 3'b010); pinLevel = '0;
    idle("R1 settle"); wr(12'h800, 32'hFFFF_FFFF, "R7 all ones");
    setPin(5, 1'b1); rd(12'h800, "R1 rise pin5");
    setPin(5, 1'b0); wr(12'h800, 32'h0000_0000, "R7 zero write");
    rd(12'h800, "R7 zero write keeps bit");
    wr(12'h800, 32'hFFFF_FFFF, "R7 all ones"); rd(12'h800, "R7 cleared");

    // R2 falling on pin 40 (word1 bit 8)
    trigCfg = oneCfg(40, 3'b100);
    setPin(40, 1'b1); rd(12'h804, "R2 no set on rise");
    setPin(40, 1'b0); rd(12'h804, "R2 fall pin40");
    wr(12'h804, 32'h0000_0100, "R7 single bit"); rd(12'h804, "R7 single cleared");

    // R3 both edges on pin 33
    trigCfg = oneCfg(33, 3'b110);
    setPin(33, 1'b1); rd(12'h804, "R3 rise"); wr(12'h804, 32'h2, "R7");
    idle("R3 steady"); rd(12'h804, "R3 steady no set");
    setPin(33, 1'b0); rd(12'h804, "R3 fall"); wr(12'h804, 32'hFFFF_FFFF, "R7");

    // R4 level high on pin 0, level low on pin 63
    cf = oneCfg(0, 3'b011) | oneCfg(63, 3'b101);
    lv = '0; lv[63] = 1'b1;
    cyc(lv, cf, 1'b0, 1'b0, 12'h0, 32'd0, "R4 arm");
    rd(12'h800, "R4 idle levels");
    setPin(0, 1'b1); wr(12'h800, 32'h1, "R4 clear while high");
    rd(12'h800, "R4 re-set after clear");
    setPin(63, 1'b0); rd(12'h804, "R4 low level pin63");
    setPin(0, 1'b0); wr(12'h800, 32'h1, "R4"); rd(12'h800, "R4 gone after release");
    setPin(63, 1'b1); wr(12'h804, 32'h8000_0000, "R4"); rd(12'h804, "R4 low gone");

    // R5 lvl only, and all-zero field
    cf = oneCfg(7, 3'b001);
    cyc(pinLevel, cf, 1'b0, 1'b0, 12'h0, 32'd0, "R5");
    setPin(7, 1'b1); setPin(7, 1'b0); setPin(8, 1'b1);
    rd(12'h800, "R5 never set");

    // R8 rising edge in the same cycle as its clear
    trigCfg = oneCfg(9, 3'b010); pinLevel = '0; idle("R8 settle");
    lv = '0; lv[9] = 1'b1;
    cyc(lv, trigCfg, 1'b1, 1'b1, 12'h800, 32'hFFFF_FFFF, "R8 clash");
    rd(12'h800, "R8 set wins");

    // R6 and R7 address decode
    wr(12'h808, 32'hFFFF_FFFF, "R7 out of range write");
    wr(12'h801, 32'hFFFF_FFFF, "R7 misaligned write");
    wr(12'h000, 32'hFFFF_FFFF, "R7 low address write");
    rd(12'h800, "R6 word0 intact");
    rd(12'h808, "R6 out of range read");
    rd(12'h802, "R6 misaligned read");
    wr(12'h800, 32'hFFFF_FFFF, "R7");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [NP-1:0] flip;
      logic [31:0] wd;
      logic [11:0] a;
      int op;
      flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      lv = pinLevel ^ flip;
      cf = trigCfg;
      if ($urandom_range(0, 49) == 0) begin
        for (int n = 0; n < NP; n++) cf[3*n +: 3] = 3'($urandom_range(0, 7));
      end
      op = $urandom_range(0, 3);
      a  = addrSet[$urandom_range(0, 3)];
      wd = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      cyc(lv, cf, op != 0, op == 1, a, wd, "R6 random read");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule